// File: doc/BRIEF.md
# Emulation Trace Bus Multiplexer

This block puts internal bus activity onto a narrow shared pin group so that an external emulator can trace it. Each bus cycle takes two clocks. In the high phase the pins carry the address of the access that is active. In the low phase they carry a packed word holding an access-type code, an instruction-queue status code, a read-data field and a flag that marks the read data as valid. The queue status and the read data trail the access by one bus cycle. This lets the read data of one access share a bus cycle with the address of the next access.

Accesses normally last one bus cycle. A wait indication can stretch an access by any number of further cycles. During a stretch the block drives null codes in the access-type and queue-status fields, so the emulator can tell that the access is still going on. Before read data is shown it is rearranged: word reads at odd addresses have their bytes swapped, and byte reads fill the unused byte with the matching address byte.

Top module: `dbg_trace_mux`

## Requirements
- R1: `phase_o` inverts on every clock. A synchronous active-high `rst` forces `phase_o`=0 and `pin_o`=0. After reset the pipeline delivers null (zero) fields until the first access is captured. The first clock after reset is released is the high phase (`phase_o`=1) of the first bus cycle.
- R2: In the high phase, `pin_o` carries the zero-extended address of the access active in that bus cycle. The address is held unchanged through every cycle of a stretched access. It is 0 in an idle bus cycle.
- R3: The inputs are sampled once per bus cycle, at the clock edge that ends a low phase. `acc_wait`=1 during an active cycle extends the access by one more bus cycle, with no limit. `acc_wait` has no effect in an idle cycle. `acc_start` has no effect while an access is being extended: the held address stays on the pins.
- R4: The low-phase type field, `pin_o[22:20]` with the default widths, shows `acc_type` only in the first bus cycle of an access. It is 0 in every later cycle of that access and in idle cycles.
- R5: The low-phase queue-status field, `pin_o[19:16]`, shows the `qstat` value sampled in the previous bus cycle. The exception is when that previous cycle was the second or a later cycle of an access; then the field is 0.
- R6: The low-phase data field, `pin_o[15:0]`, shows read data in the bus cycle after the last cycle of a read access. `rd_data` is sampled in that last cycle. `rd_data[15:8]` is the byte at the access address A and `rd_data[7:0]` is the byte at A+1. After writes and idle cycles the field is 0.
- R7: A word read (`acc_word`=1) at an even address shows `rd_data` unchanged. At an odd address it shows `{rd_data[7:0], rd_data[15:8]}`.
- R8: A byte read at an even address shows `{rd_data[15:8], addr[7:0]}`. At an odd address it shows `{addr[15:8], rd_data[15:8]}`.
- R9: The flag bit `pin_o[23]` is 1 only when the data field holds data from a CPU read (`acc_cpu`=1). A non-CPU read still drives its formatted data, with the flag at 0.
- R10: When accesses run back to back, the read data of one access appears in the low phase of the first cycle of the next access. That next access's address appears in the high phase of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; two clocks form one bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | A new access begins in this bus cycle |
| acc_wait | input | 1 | The active access continues into the next bus cycle |
| acc_addr | input | ADDR_W | Address of the starting access |
| acc_type | input | TYPE_W | Access-type code of the starting access |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_read | input | 1 | 1 = read, 0 = write |
| acc_cpu | input | 1 | 1 = CPU-initiated access |
| rd_data | input | 16 | Read data, sampled in the last cycle of a read |
| qstat | input | QST_W | Instruction-queue status code for this bus cycle |
| pin_o | output | PIN_W | Shared trace pins |
| phase_o | output | 1 | 1 = high (address) phase, 0 = low (field) phase |

## Verification
The hardest case to reach from the ports is a stretched read whose data, queue-status null and type null all have to line up with the start of the next access. Random stimulus alone rarely builds long stretches that end in a read followed at once by a new access. The bench therefore drives directed sequences: a six-cycle stretched read followed at once by another access, a start request pushed in during a stretch, and a wait pulse while idle. It then adds seeded random traffic that has a raised chance of waits, so chained continuations of varying length occur in large numbers.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;
   localparam int DATA_W = 16;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } trace_phase_e;
endpackage

// File: rtl/dbg_trace_fmt.sv
module dbg_trace_fmt
   import dbg_trace_pkg::*;
(
   input  logic [15:0]       addr_lo,
   input  logic              word,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] shown
);
   localparam int BYTE_W = DATA_W / 2;

   logic odd;
   assign odd = addr_lo[0];

   always_comb begin
      if (word) begin
         shown = odd ? {raw[BYTE_W-1:0], raw[DATA_W-1:BYTE_W]} : raw;
      end else begin
         shown = odd ? {addr_lo[15:8], raw[DATA_W-1:BYTE_W]}
                     : {raw[DATA_W-1:BYTE_W], addr_lo[7:0]};
      end
   end
endmodule

// File: rtl/dbg_trace_track.sv
module dbg_trace_track #(
   parameter int ADDR_W = 23
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              start_i,
   input  logic              wait_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              word_i,
   input  logic              rd_i,
   input  logic              cpu_i,
   output logic              active_o,
   output logic              first_o,
   output logic              cont_o,
   output logic              last_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              word_o,
   output logic              rd_o,
   output logic              cpu_o
);
   logic              cont_q;
   logic [ADDR_W-1:0] h_addr;
   logic              h_word, h_rd, h_cpu;

   assign first_o  = start_i && !cont_q;
   assign cont_o   = cont_q;
   assign active_o = first_o || cont_q;
   assign last_o   = active_o && !wait_i;
   assign addr_o   = first_o ? addr_i : h_addr;
   assign word_o   = first_o ? word_i : h_word;
   assign rd_o     = first_o ? rd_i   : h_rd;
   assign cpu_o    = first_o ? cpu_i  : h_cpu;

   always_ff @(posedge clk) begin
      if (rst) begin
         cont_q <= 1'b0;
         h_addr <= '0;
         h_word <= 1'b0;
         h_rd   <= 1'b0;
         h_cpu  <= 1'b0;
      end else if (step) begin
         cont_q <= active_o && wait_i;
         if (first_o) begin
            h_addr <= addr_i;
            h_word <= word_i;
            h_rd   <= rd_i;
            h_cpu  <= cpu_i;
         end
      end
   end
endmodule

// File: rtl/dbg_trace_mux.sv
module dbg_trace_mux
   import dbg_trace_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int TYPE_W = 3,
   parameter int QST_W  = 4,
   localparam int LOW_W = 1 + TYPE_W + QST_W + DATA_W,
   localparam int PIN_W = (ADDR_W > LOW_W) ? ADDR_W : LOW_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc_start,
   input  logic              acc_wait,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [TYPE_W-1:0] acc_type,
   input  logic              acc_word,
   input  logic              acc_read,
   input  logic              acc_cpu,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [QST_W-1:0]  qstat,
   output logic [PIN_W-1:0]  pin_o,
   output logic              phase_o
);
   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must be at least 16");
      end
      if (TYPE_W < 1 || QST_W < 1) begin : g_bad_field
         $error("TYPE_W and QST_W must be at least 1");
      end
   endgenerate

   trace_phase_e      ph_q;
   logic [PIN_W-1:0]  pin_q;
   logic [LOW_W-1:0]  low_q;
   logic [QST_W-1:0]  qpend_q;
   logic [DATA_W-1:0] ivd_q;
   logic              vld_q;

   logic              step;
   logic              t_active, t_first, t_cont, t_last;
   logic [ADDR_W-1:0] t_addr;
   logic              t_word, t_rd, t_cpu;
   logic [DATA_W-1:0] fmt_data;
   logic [ADDR_W-1:0] addr_shown;
   logic [PIN_W-1:0]  addr_pin, low_pin;
   logic [TYPE_W-1:0] type_shown;

   assign step = (ph_q == PH_LOW);

   dbg_trace_track #(.ADDR_W(ADDR_W)) track_i (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .start_i  (acc_start),
      .wait_i   (acc_wait),
      .addr_i   (acc_addr),
      .word_i   (acc_word),
      .rd_i     (acc_read),
      .cpu_i    (acc_cpu),
      .active_o (t_active),
      .first_o  (t_first),
      .cont_o   (t_cont),
      .last_o   (t_last),
      .addr_o   (t_addr),
      .word_o   (t_word),
      .rd_o     (t_rd),
      .cpu_o    (t_cpu)
   );

   dbg_trace_fmt fmt_i (
      .addr_lo (t_addr[15:0]),
      .word    (t_word),
      .raw     (rd_data),
      .shown   (fmt_data)
   );

   assign addr_shown = t_active ? t_addr : '0;
   assign type_shown = t_first ? acc_type : '0;

   generate
      if (PIN_W > ADDR_W) begin : g_pad_addr
         assign addr_pin = {{(PIN_W - ADDR_W){1'b0}}, addr_shown};
      end else begin : g_full_addr
         assign addr_pin = addr_shown;
      end
      if (PIN_W > LOW_W) begin : g_pad_low
         assign low_pin = {{(PIN_W - LOW_W){1'b0}}, low_q};
      end else begin : g_full_low
         assign low_pin = low_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q    <= PH_LOW;
         pin_q   <= '0;
         low_q   <= '0;
         qpend_q <= '0;
         ivd_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         ph_q <= step ? PH_HIGH : PH_LOW;
         if (step) begin
            pin_q   <= addr_pin;
            low_q   <= {vld_q, type_shown, qpend_q, ivd_q};
            qpend_q <= t_cont ? '0 : qstat;
            ivd_q   <= (t_last && t_rd) ? fmt_data : '0;
            vld_q   <= t_last && t_rd && t_cpu;
         end else begin
            pin_q <= low_pin;
         end
      end
   end

   assign pin_o   = pin_q;
   assign phase_o = (ph_q == PH_HIGH);
endmodule

// File: rtl/dbg_trace_chk.sv
module dbg_trace_chk #(
   parameter int ADDR_W = 23,
   parameter int TYPE_W = 3,
   parameter int QST_W  = 4,
   parameter int PIN_W  = 24
) (
   input logic              clk,
   input logic              rst,
   input logic              acc_start,
   input logic              acc_wait,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_read,
   input logic              acc_cpu,
   input logic [PIN_W-1:0]  pin_o,
   input logic              phase_o
);
   localparam int QLO  = 16;
   localparam int TLO  = 16 + QST_W;
   localparam int FLAG = 16 + QST_W + TYPE_W;

   logic c_cont, c_step, c_new;
   assign c_step = !phase_o;
   assign c_new  = acc_start && !c_cont;

   always_ff @(posedge clk) begin
      if (rst) c_cont <= 1'b0;
      else if (c_step) c_cont <= (acc_start || c_cont) && acc_wait;
   end

   p_phase_toggle_r1: assert property (@(posedge clk) disable iff (rst)
      !phase_o |=> phase_o);
   p_phase_back_r1: assert property (@(posedge clk) disable iff (rst)
      phase_o |=> !phase_o);
   p_high_addr_r2: assert property (@(posedge clk) disable iff (rst)
      (c_step && c_new) |=> (pin_o[ADDR_W-1:0] == $past(acc_addr)) && phase_o);
   p_acc_null_r4: assert property (@(posedge clk) disable iff (rst)
      (c_step && c_cont) |=> ##1 (pin_o[TLO +: TYPE_W] == '0));
   p_qst_null_r5: assert property (@(posedge clk) disable iff (rst)
      (c_step && c_cont) |=> ##3 (pin_o[QLO +: QST_W] == '0));
   p_write_nodata_r6: assert property (@(posedge clk) disable iff (rst)
      (c_step && c_new && !acc_wait && !acc_read) |=> ##3
      ((pin_o[15:0] == 16'h0) && !pin_o[FLAG]));
   p_noncpu_flag_r9: assert property (@(posedge clk) disable iff (rst)
      (c_step && c_new && !acc_wait && acc_read && !acc_cpu) |=> ##3 !pin_o[FLAG]);
endmodule

bind dbg_trace_mux dbg_trace_chk #(
   .ADDR_W (ADDR_W),
   .TYPE_W (TYPE_W),
   .QST_W  (QST_W),
   .PIN_W  (PIN_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .acc_start (acc_start),
   .acc_wait  (acc_wait),
   .acc_addr  (acc_addr),
   .acc_read  (acc_read),
   .acc_cpu   (acc_cpu),
   .pin_o     (pin_o),
   .phase_o   (phase_o)
);

// File: tb/dbg_trace_mux_tb.sv
module dbg_trace_mux_tb_top;
   localparam int AW = 23;
   localparam int TW = 3;
   localparam int QW = 4;
   localparam int PW = 24;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          acc_start = 0, acc_wait = 0, acc_word = 0, acc_read = 0, acc_cpu = 0;
   logic [AW-1:0] acc_addr = '0;
   logic [TW-1:0] acc_type = '0;
   logic [15:0]   rd_data = '0;
   logic [QW-1:0] qstat = '0;
   logic [PW-1:0] pin_o;
   logic          phase_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dbg_trace_mux dut_i (
      .clk(clk), .rst(rst), .acc_start(acc_start), .acc_wait(acc_wait),
      .acc_addr(acc_addr), .acc_type(acc_type), .acc_word(acc_word),
      .acc_read(acc_read), .acc_cpu(acc_cpu), .rd_data(rd_data),
      .qstat(qstat), .pin_o(pin_o), .phase_o(phase_o)
   );

   // bench model state, built from the requirements
   logic          m_cont = 0, m_word = 0, m_rd = 0, m_cpu = 0;
   logic [AW-1:0] m_addr = '0;
   logic [QW-1:0] m_qpend = '0;
   logic [15:0]   m_ivd = '0;
   logic          m_vld = 0;
   string         m_tag = "R6";

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_fmt(input logic [AW-1:0] a, input logic w,
                                           input logic [15:0] d);
      if (w) return a[0] ? {d[7:0], d[15:8]} : d;
      return a[0] ? {a[15:8], d[15:8]} : {d[15:8], a[7:0]};
   endfunction

   // One bus cycle: drive at a negedge with phase_o low, check both phases.
   task automatic bus_cycle(input logic st, input logic wt, input logic [AW-1:0] ad,
                            input logic [TW-1:0] ty, input logic wd, input logic rd,
                            input logic cp, input logic [15:0] dat, input logic [QW-1:0] qs);
      logic first, active, last, c_word, c_rd, c_cpu;
      logic [AW-1:0] c_addr;
      logic [TW-1:0] e_type;
      string d_tag;
      acc_start = st; acc_wait = wt; acc_addr = ad; acc_type = ty;
      acc_word = wd; acc_read = rd; acc_cpu = cp; rd_data = dat; qstat = qs;
      first  = st && !m_cont;
      active = first || m_cont;
      last   = active && !wt;
      c_addr = first ? ad : m_addr;
      c_word = first ? wd : m_word;
      c_rd   = first ? rd : m_rd;
      c_cpu  = first ? cp : m_cpu;
      e_type = first ? ty : '0;
      d_tag  = (first && m_vld) ? "R10" : m_tag;
      @(negedge clk);
      chk("R1 high phase", {31'b0, phase_o}, 32'd1);
      chk(m_cont ? "R3 held address" : "R2 address", {9'b0, pin_o[AW-1:0]},
          active ? {9'b0, c_addr} : 32'd0);
      @(negedge clk);
      chk("R1 low phase", {31'b0, phase_o}, 32'd0);
      chk(m_cont ? "R4 type null" : "R4 type", {29'b0, pin_o[22:20]}, {29'b0, e_type});
      chk("R5 qstat", {28'b0, pin_o[19:16]}, {28'b0, m_qpend});
      chk(d_tag, {16'b0, pin_o[15:0]}, {16'b0, m_ivd});
      chk("R9 flag", {31'b0, pin_o[23]}, {31'b0, m_vld});
      // advance model
      m_qpend = m_cont ? '0 : qs;
      m_ivd   = (last && c_rd) ? exp_fmt(c_addr, c_word, dat) : 16'h0;
      m_vld   = last && c_rd && c_cpu;
      m_tag   = (last && c_rd) ? (c_word ? "R7" : "R8") : "R6";
      if (first) begin
         m_addr = ad; m_word = wd; m_rd = rd; m_cpu = cp;
      end
      m_cont = active && wt;
   endtask

   initial begin
      #(50000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (4) @(negedge clk);
      chk("R1 reset pins", {8'b0, pin_o}, 32'd0);
      chk("R1 reset phase", {31'b0, phase_o}, 32'd0);
      rst = 1'b0;
      // first cycle after reset: idle, null fields expected
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h0, 4'h9);
      // word read even (R7), then odd misaligned (R7)
      bus_cycle(1, 0, 23'h001234, 3'd5, 1, 1, 1, 16'hA1B2, 4'h3);
      bus_cycle(1, 0, 23'h002345, 3'd6, 1, 1, 1, 16'hC3D4, 4'h4);
      // byte reads even and odd (R8)
      bus_cycle(1, 0, 23'h00ABCE, 3'd2, 0, 1, 1, 16'h5E00, 4'h5);
      bus_cycle(1, 0, 23'h00ABCF, 3'd2, 0, 1, 1, 16'h7F00, 4'h6);
      // non-CPU read (R9), then write (R6)
      bus_cycle(1, 0, 23'h004000, 3'd1, 1, 1, 0, 16'h1357, 4'h7);
      bus_cycle(1, 0, 23'h004002, 3'd3, 1, 0, 1, 16'hFFFF, 4'h8);
      // wait while idle is ignored (R3)
      bus_cycle(0, 1, 23'h7FFFFF, 3'd7, 1, 1, 1, 16'hEEEE, 4'hA);
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h0, 4'hB);
      // six-cycle stretched read, start attempt inside it ignored (R3, R4, R5)
      bus_cycle(1, 1, 23'h010001, 3'd4, 1, 1, 1, 16'h0000, 4'hC);
      bus_cycle(0, 1, '0, '0, 0, 0, 0, 16'h0, 4'hD);
      bus_cycle(1, 1, 23'h055555, 3'd7, 0, 0, 0, 16'h0, 4'hE);
      bus_cycle(0, 1, '0, '0, 0, 0, 0, 16'h0, 4'hF);
      bus_cycle(0, 1, '0, '0, 0, 0, 0, 16'h0, 4'h1);
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h2468, 4'h2);
      // back-to-back next access shows previous read data (R10)
      bus_cycle(1, 0, 23'h020000, 3'd3, 1, 1, 1, 16'h9999, 4'h3);
      bus_cycle(1, 0, 23'h020002, 3'd2, 1, 0, 1, 16'h0, 4'h4);
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h0, 4'h5);
      // seeded random traffic with frequent waits
      for (int i = 0; i < 800; i++) begin
         bus_cycle(($urandom % 4) != 0, ($urandom % 3) == 0, AW'($urandom),
                   TW'($urandom), $urandom % 2, $urandom % 2, ($urandom % 4) != 0,
                   16'($urandom), QW'($urandom));
      end
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h0, 4'h0);
      bus_cycle(0, 0, '0, '0, 0, 0, 0, 16'h0, 4'h0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule